// File: doc/BRIEF.md
# System Control Coprocessor Register Unit

This block sits beside a 32-bit core and serves its coprocessor move instructions for system control. Each request arrives in a single cycle. It carries a direction (read into a core register, or write from one), a control register number, a 10-bit operation code and 32 bits of write data. The block holds four storage words: the system control word, the page table base, the data fault status and the fault address. It also returns two fixed identification words, one for the CPU and one for the cache type.

Writes to the cache maintenance register and the TLB maintenance register change no storage. Instead they produce one-cycle pulses for the memory system. Cache maintenance uses one output bit per operation, and line operations also pass the write data along as the line address. Operation codes that these two registers do not recognise are dropped without an error. Every other unsupported combination of register and operation raises an illegal-access pulse and leaves all state untouched.

The request side has no back-pressure. The block accepts a request in every cycle in which `req_valid` is high, so back-to-back requests are allowed. Each response appears exactly one cycle later and lasts one cycle. The core must not stall it.

A separate combinational pin tells the core whether an instruction word belongs to this coprocessor.

Top module: `sysctl_cop`

## Requirements
- R1: After reset, all four storage words read as zero, and `rsp_valid`, `rsp_illegal`, `tlb_flush`, `maint_pulse` and `maint_line_addr` are all zero.
- R2: Registers 1 (system control), 2 (page table base), 3 (fault status) and 4 (fault address) are written and read only with operation code 0. A write shows on the matching storage output in the cycle after the request.
- R3: A read of register 0 returns the CPU identification parameter with operation code 0, and the cache type parameter with operation code 1.
- R4: A write to register 5 sets exactly one bit of `maint_pulse` in the next cycle, as follows:
  - code 28 sets bit 0 (invalidate instruction and data cache);
  - code 20 sets bit 1 (invalidate instruction cache);
  - code 12 sets bit 2 (invalidate data cache);
  - code 10 sets bit 3 (clean data cache);
  - code 14 sets bit 4 (flush data cache);
  - code 13 sets bit 5 (invalidate data line);
  - code 11 sets bit 6 (clean data line);
  - code 15 sets bit 7 (flush data line).
- R5: A line operation (bits 5 to 7) loads the write data into `maint_line_addr` in the same cycle as its pulse. Any other request leaves `maint_line_addr` unchanged.
- R6: A write to register 6 with an operation code from 2 to 6 inclusive pulses `tlb_flush` for one cycle.
- R7: A write to register 5 or 6 with an unrecognised operation code produces no pulse and no illegal flag, and changes no storage.
- R8: A write to register 0, to registers 7 to 15, or to registers 1 to 4 with a nonzero operation code pulses `rsp_illegal` in the next cycle.
- R9: A read of any combination other than those in R2 and R3 pulses `rsp_illegal`, and `rsp_valid` stays low.
- R10: A flagged request changes no storage word and raises no maintenance pulse.
- R11: `rsp_valid`, `rsp_illegal`, `maint_pulse` and `tlb_flush` are high only in the cycle after an accepted request. `rsp_rdata` is zero whenever `rsp_valid` is low.
- R12: `insn_claim` is high exactly when bits 31 to 25 of `insn` equal 1110000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted every cycle |
| req_write | input | 1 | 1 = write from core, 0 = read into core |
| req_reg | input | 4 | Control register number |
| req_op | input | 10 | Operation code |
| req_wdata | input | 32 | Write data or line address |
| rsp_valid | output | 1 | Read data valid, one cycle after request |
| rsp_rdata | output | 32 | Read data |
| rsp_illegal | output | 1 | Illegal-access pulse |
| maint_pulse | output | 8 | One-hot cache maintenance pulses |
| maint_line_addr | output | 32 | Line address for line operations |
| tlb_flush | output | 1 | Whole-TLB flush pulse |
| sys_ctrl | output | 32 | System control word |
| pt_base | output | 32 | Page table base |
| fault_status | output | 32 | Data fault status |
| fault_addr | output | 32 | Fault address |
| insn | input | 32 | Instruction word to classify |
| insn_claim | output | 1 | Instruction belongs to this coprocessor |

## Verification
The four storage words are brought out directly. A write that is lost, goes to the wrong register or is let through by a flagged request therefore shows up on the ports one cycle after the request. A decode error in the maintenance tables shows as a wrong or extra pulse bit on the very next cycle. The bench sweeps every register number against every operation code in both directions. It keeps its own model of the storage and compares all outputs after each request, so any misdecoded pair is caught at the request that causes it.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int NUM_STORE   = 4;
  localparam int NUM_MAINT   = 8;
  localparam int CODE_W      = 10;
  localparam logic [6:0] CLAIM_PATTERN = 7'b1110000;

  localparam int REG_ID_NUM  = 0;
  localparam int REG_CACHE   = 5;
  localparam int REG_TLB     = 6;
  localparam int TLB_OP_LO   = 2;
  localparam int TLB_OP_HI   = 6;

  typedef enum logic [2:0] {
    MT_INV_ALL_ID   = 3'd0,
    MT_INV_ALL_I    = 3'd1,
    MT_INV_ALL_D    = 3'd2,
    MT_CLEAN_ALL_D  = 3'd3,
    MT_FLUSH_ALL_D  = 3'd4,
    MT_INV_LINE_D   = 3'd5,
    MT_CLEAN_LINE_D = 3'd6,
    MT_FLUSH_LINE_D = 3'd7
  } maint_e;

  typedef enum logic [1:0] {
    RS_NONE  = 2'd0,
    RS_ID    = 2'd1,
    RS_CTYPE = 2'd2,
    RS_STORE = 2'd3
  } rdsrc_e;

  localparam logic [NUM_MAINT-1:0] LINE_MASK = 8'b1110_0000;

  function automatic logic [CODE_W-1:0] maint_code(input int idx);
    case (idx)
      0:       maint_code = 10'd28;
      1:       maint_code = 10'd20;
      2:       maint_code = 10'd12;
      3:       maint_code = 10'd10;
      4:       maint_code = 10'd14;
      5:       maint_code = 10'd13;
      6:       maint_code = 10'd11;
      default: maint_code = 10'd15;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int OP_W  = 10,
  localparam int IDX_W = $clog2(NUM_STORE)
) (
  input  logic                 valid,
  input  logic                 write,
  input  logic [REG_W-1:0]     reg_num,
  input  logic [OP_W-1:0]      op,
  output logic [NUM_STORE-1:0] store_wr,
  output logic [IDX_W-1:0]     store_idx,
  output rdsrc_e               rd_src,
  output logic [NUM_MAINT-1:0] maint_hit,
  output logic                 tlb_hit,
  output logic                 illegal
);

  logic [NUM_MAINT-1:0] code_match;
  logic                 is_store;
  logic                 op_zero;
  logic                 tlb_range;

  for (genvar g = 0; g < NUM_MAINT; g++) begin : g_code
    assign code_match[g] = (op == OP_W'(maint_code(g)));
  end

  assign is_store  = (reg_num >= REG_W'(1)) && (reg_num <= REG_W'(NUM_STORE));
  assign store_idx = IDX_W'(reg_num - REG_W'(1));
  assign op_zero   = (op == '0);
  assign tlb_range = (op >= OP_W'(TLB_OP_LO)) && (op <= OP_W'(TLB_OP_HI));

  always_comb begin
    store_wr  = '0;
    rd_src    = RS_NONE;
    maint_hit = '0;
    tlb_hit   = 1'b0;
    illegal   = 1'b0;
    if (valid) begin
      if (write) begin
        if (is_store) begin
          if (op_zero) store_wr[store_idx] = 1'b1;
          else         illegal = 1'b1;
        end else if (reg_num == REG_W'(REG_CACHE)) begin
          maint_hit = code_match;
        end else if (reg_num == REG_W'(REG_TLB)) begin
          tlb_hit = tlb_range;
        end else begin
          illegal = 1'b1;
        end
      end else begin
        if (reg_num == REG_W'(REG_ID_NUM) && op_zero)                  rd_src = RS_ID;
        else if (reg_num == REG_W'(REG_ID_NUM) && op == OP_W'(1))      rd_src = RS_CTYPE;
        else if (is_store && op_zero)                                  rd_src = RS_STORE;
        else                                                           illegal = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NUM_STORE)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_STORE-1:0]              wr_en,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [IDX_W-1:0]                  rd_idx,
  output logic [DATA_W-1:0]                 rd_data,
  output logic [NUM_STORE-1:0][DATA_W-1:0]  words
);

  for (genvar g = 0; g < NUM_STORE; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)        words[g] <= '0;
      else if (wr_en[g]) words[g] <= wdata;
    end
  end

  assign rd_data = words[rd_idx];

endmodule

// File: rtl/sysctl_resp.sv
module sysctl_resp
  import sysctl_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] ID_WORD    = 32'h0,
  parameter logic [31:0] CTYPE_WORD = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rdsrc_e               rd_src,
  input  logic [DATA_W-1:0]    store_rd,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_MAINT-1:0] maint_hit,
  input  logic                 tlb_hit,
  input  logic                 illegal,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_illegal,
  output logic [NUM_MAINT-1:0] maint_pulse,
  output logic [DATA_W-1:0]    line_addr,
  output logic                 tlb_flush
);

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    case (rd_src)
      RS_ID:    rd_next = DATA_W'(ID_WORD);
      RS_CTYPE: rd_next = DATA_W'(CTYPE_WORD);
      RS_STORE: rd_next = store_rd;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
      maint_pulse <= '0;
      tlb_flush   <= 1'b0;
      line_addr   <= '0;
    end else begin
      rsp_valid   <= (rd_src != RS_NONE);
      rsp_rdata   <= rd_next;
      rsp_illegal <= illegal;
      maint_pulse <= maint_hit;
      tlb_flush   <= tlb_hit;
      if (|(maint_hit & LINE_MASK)) line_addr <= wdata;
    end
  end

endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          REG_W      = 4,
  parameter int          OP_W       = 10,
  parameter logic [31:0] ID_WORD    = 32'h4d11_0863,
  parameter logic [31:0] CTYPE_WORD = 32'h0d15_2152
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [REG_W-1:0]     req_reg,
  input  logic [OP_W-1:0]      req_op,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_illegal,
  output logic [7:0]           maint_pulse,
  output logic [DATA_W-1:0]    maint_line_addr,
  output logic                 tlb_flush,
  output logic [DATA_W-1:0]    sys_ctrl,
  output logic [DATA_W-1:0]    pt_base,
  output logic [DATA_W-1:0]    fault_status,
  output logic [DATA_W-1:0]    fault_addr,
  input  logic [31:0]          insn,
  output logic                 insn_claim
);

  localparam int IDX_W = $clog2(NUM_STORE);

  logic [NUM_STORE-1:0]             store_wr;
  logic [IDX_W-1:0]                 store_idx;
  rdsrc_e                           rd_src;
  logic [NUM_MAINT-1:0]             maint_hit;
  logic                             tlb_hit;
  logic                             illegal;
  logic [DATA_W-1:0]                store_rd;
  logic [NUM_STORE-1:0][DATA_W-1:0] words;

  sysctl_decode #(.REG_W(REG_W), .OP_W(OP_W)) u_dec (
    .valid     (req_valid),
    .write     (req_write),
    .reg_num   (req_reg),
    .op        (req_op),
    .store_wr  (store_wr),
    .store_idx (store_idx),
    .rd_src    (rd_src),
    .maint_hit (maint_hit),
    .tlb_hit   (tlb_hit),
    .illegal   (illegal)
  );

  sysctl_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_wr),
    .wdata   (req_wdata),
    .rd_idx  (store_idx),
    .rd_data (store_rd),
    .words   (words)
  );

  sysctl_resp #(.DATA_W(DATA_W), .ID_WORD(ID_WORD), .CTYPE_WORD(CTYPE_WORD)) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_src      (rd_src),
    .store_rd    (store_rd),
    .wdata       (req_wdata),
    .maint_hit   (maint_hit),
    .tlb_hit     (tlb_hit),
    .illegal     (illegal),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_illegal (rsp_illegal),
    .maint_pulse (maint_pulse),
    .line_addr   (maint_line_addr),
    .tlb_flush   (tlb_flush)
  );

  assign sys_ctrl     = words[0];
  assign pt_base      = words[1];
  assign fault_status = words[2];
  assign fault_addr   = words[3];

  assign insn_claim = (insn[31:25] == CLAIM_PATTERN);

endmodule

// File: rtl/sysctl_cop_chk.sv
module sysctl_cop_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int OP_W   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [REG_W-1:0]  req_reg,
  input logic [OP_W-1:0]   req_op,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_illegal,
  input logic [7:0]        maint_pulse,
  input logic              tlb_flush,
  input logic [DATA_W-1:0] sys_ctrl,
  input logic [DATA_W-1:0] pt_base,
  input logic [DATA_W-1:0] fault_status,
  input logic [DATA_W-1:0] fault_addr
);

  assert_maint_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(maint_pulse));

  assert_valid_vs_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_illegal));

  assert_flag_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> (maint_pulse == '0 && !tlb_flush));

  assert_flag_keeps_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> ($stable(sys_ctrl) && $stable(pt_base) &&
                     $stable(fault_status) && $stable(fault_addr)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (maint_pulse == '0 && !tlb_flush && !rsp_valid && !rsp_illegal));

  assert_rdata_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == '0));

  assert_reg0_write_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_reg == '0) |=> rsp_illegal);

  assert_tlb_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_reg == REG_W'(6) &&
     req_op >= OP_W'(2) && req_op <= OP_W'(6)) |=> tlb_flush);

endmodule

bind sysctl_cop sysctl_cop_chk #(.DATA_W(DATA_W), .REG_W(REG_W), .OP_W(OP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_reg      (req_reg),
  .req_op       (req_op),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .rsp_illegal  (rsp_illegal),
  .maint_pulse  (maint_pulse),
  .tlb_flush    (tlb_flush),
  .sys_ctrl     (sys_ctrl),
  .pt_base      (pt_base),
  .fault_status (fault_status),
  .fault_addr   (fault_addr)
);

// File: tb/sysctl_cop_tb_top.sv
module sysctl_cop_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] TB_ID      = 32'hA5C3_0107;
  localparam logic [31:0] TB_CTYPE   = 32'h1F2E_3D4C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_reg = '0;
  logic [9:0]  req_op = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_illegal, tlb_flush, insn_claim;
  logic [31:0] rsp_rdata, maint_line_addr, sys_ctrl, pt_base, fault_status, fault_addr;
  logic [7:0]  maint_pulse;
  logic [31:0] insn = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] model [4];
  logic [31:0] model_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_cop #(.ID_WORD(TB_ID), .CTYPE_WORD(TB_CTYPE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_reg(req_reg),
    .req_op(req_op), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal),
    .maint_pulse(maint_pulse), .maint_line_addr(maint_line_addr),
    .tlb_flush(tlb_flush), .sys_ctrl(sys_ctrl), .pt_base(pt_base),
    .fault_status(fault_status), .fault_addr(fault_addr),
    .insn(insn), .insn_claim(insn_claim)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    check(tag, "sys_ctrl", sys_ctrl, model[0]);
    check(tag, "pt_base", pt_base, model[1]);
    check(tag, "fault_status", fault_status, model[2]);
    check(tag, "fault_addr", fault_addr, model[3]);
  endtask

  function automatic int cache_bit(input int code);
    case (code)
      28: return 0;
      20: return 1;
      12: return 2;
      10: return 3;
      14: return 4;
      13: return 5;
      11: return 6;
      15: return 7;
      default: return -1;
    endcase
  endfunction

  task automatic do_req(input bit w, input int r, input int o, input logic [31:0] d);
    logic        e_illegal = 1'b0;
    logic        e_valid   = 1'b0;
    logic [31:0] e_rdata   = '0;
    logic [7:0]  e_maint   = '0;
    logic        e_tlb     = 1'b0;
    string       tag;
    int          cb;
    req_valid = 1'b1; req_write = w; req_reg = 4'(r); req_op = 10'(o); req_wdata = d;
    if (w) begin
      if (r >= 1 && r <= 4) begin
        if (o == 0) model[r-1] = d; else e_illegal = 1'b1;
        tag = (o == 0) ? "R2" : "R8";
      end else if (r == 5) begin
        cb = cache_bit(o);
        if (cb >= 0) begin
          e_maint[cb] = 1'b1;
          if (cb >= 5) model_line = d;
          tag = (cb >= 5) ? "R5" : "R4";
        end else tag = "R7";
      end else if (r == 6) begin
        e_tlb = (o >= 2 && o <= 6);
        tag = e_tlb ? "R6" : "R7";
      end else begin
        e_illegal = 1'b1;
        tag = "R8";
      end
    end else begin
      if (r == 0 && o == 0)                 begin e_valid = 1'b1; e_rdata = TB_ID;      tag = "R3"; end
      else if (r == 0 && o == 1)            begin e_valid = 1'b1; e_rdata = TB_CTYPE;   tag = "R3"; end
      else if (r >= 1 && r <= 4 && o == 0)  begin e_valid = 1'b1; e_rdata = model[r-1]; tag = "R2"; end
      else begin e_illegal = 1'b1; tag = "R9"; end
    end
    @(negedge clk);
    check(tag, "rsp_valid", 32'(rsp_valid), 32'(e_valid));
    check(tag, "rsp_rdata", rsp_rdata, e_rdata);
    check(tag, "rsp_illegal", 32'(rsp_illegal), 32'(e_illegal));
    check(tag, "maint_pulse", 32'(maint_pulse), 32'(e_maint));
    check(tag, "tlb_flush", 32'(tlb_flush), 32'(e_tlb));
    check("R5", "line_addr", maint_line_addr, model_line);
    check_regs(e_illegal ? "R10" : "R2");
  endtask

  task automatic idle_check();
    req_valid = 1'b0;
    req_write = 1'b1; req_reg = 4'd5; req_op = 10'd28;
    @(negedge clk);
    check("R11", "idle rsp_valid", 32'(rsp_valid), 32'd0);
    check("R11", "idle rsp_illegal", 32'(rsp_illegal), 32'd0);
    check("R11", "idle maint", 32'(maint_pulse), 32'd0);
    check("R11", "idle tlb", 32'(tlb_flush), 32'd0);
    check("R11", "idle rdata", rsp_rdata, 32'd0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    model_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_regs("R1");
    check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1", "rsp_illegal", 32'(rsp_illegal), 32'd0);
    check("R1", "maint", 32'(maint_pulse), 32'd0);
    check("R1", "tlb", 32'(tlb_flush), 32'd0);
    check("R1", "line_addr", maint_line_addr, 32'd0);

    // directed: write then read back each store word
    for (int r = 1; r <= 4; r++) do_req(1'b1, r, 0, 32'h1357_0000 + 32'(r * 32'h1111));
    for (int r = 1; r <= 4; r++) do_req(1'b0, r, 0, 32'hFFFF_FFFF);
    idle_check();

    // exhaustive sweep: both directions, every register and operation code
    for (int w = 0; w < 2; w++) begin
      for (int r = 0; r < 16; r++) begin
        for (int o = 0; o < 1024; o++) begin
          do_req(w[0], r, o, 32'(((w * 16 + r) * 1024 + o + 1) * 32'h9E37_79B9));
        end
        idle_check();
      end
    end

    // R12 claim decode
    for (int p = 0; p < 128; p++) begin
      insn = {7'(p), 25'h0ABCDEF};
      #1;
      check("R12", "insn_claim", 32'(insn_claim), 32'(p == 7'b1110000));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule